// File: doc/BRIEF.md
# Transmit Symbol Front End

This block sits in the byte-rate part of a serial transmitter, ahead of the 8B/10B encoder. At each byte boundary it looks at an 8-bit data byte and a small set of control inputs. It then issues one tagged symbol request to the encoder. The request is one of five kinds: a plain data byte, a control (special) character, a code violation, a K28.5 fill character, or a raw 10-bit word that bypasses the encoder.

Two active-low load enables serve two kinds of FIFO. The immediate enable loads the byte present at the same boundary. The next-boundary enable loads the byte present at the following boundary. When neither enable asks for a load, the block fills the byte slot with K28.5.

The block also produces a byte-rate read strobe for an asynchronous FIFO. It registers the serial line outputs, so that a transmitter-off control can force the two optical-drive lines to zero while a third loopback line keeps carrying the data.

The clock `clk` runs at the bit rate. A byte period is `SLOTS` bit slots (default 10). A byte boundary is the edge that ends the last slot.

Top module: `tx_symbol_front`

## Requirements
- R1: While `rst` is high, and after it is released, `sym_kind` is FILL (3), `sym_word` is 10'h1BC, `sym_valid` is 0 and `rd_n` is 1. Reset also clears a pending next-boundary load, so the first symbol after reset is FILL when both enables are high.
- R2: When `en_now_n` is low at a boundary, in encoded mode, with `viol_req` and `spec_sel` low, the symbol is DATA (0) and `sym_word` is {2'b00, data_in}, using the data present at that boundary.
- R3: When `en_next_n` is low at one boundary, the data present at the next boundary is loaded, even if `en_now_n` is high at that next boundary.
- R4: With both enables high and no pending load, the data inputs are ignored and the symbol is FILL with `sym_word` = 10'h1BC (bit 8 flags a control code, bits 7:0 hold 8'hBC).
- R5: A loaded byte with `spec_sel` high, in encoded mode, gives SPECIAL (1) with `sym_word` = {2'b00, data_in}.
- R6: In encoded mode, `viol_req` high at a boundary gives VIOL (2) with `sym_word` = 0. This holds whatever the enables, `spec_sel` and data are, and any pending load is consumed.
- R7: With `raw_mode` high and a load, the symbol is RAW (4) with `sym_word` = {viol_req, spec_sel, data_in} (bit 9 = viol_req, bit 8 = spec_sel). Without a load in raw mode, the symbol is FILL.
- R8: `sym_valid` pulses high for exactly one cycle after each boundary. The boundaries fall every `SLOTS` cycles. The first pulse is seen `SLOTS` cycles after reset release, and the symbol outputs change only together with that pulse.
- R9: In the byte period after a boundary at which `en_now_n` was low, `rd_n` is low for bit slots 0 to `LOW_SLOTS-1` (default 6 of 10) and high for the rest. Otherwise `rd_n` stays high for the whole period.
- R10: `line_out` is `ser_bit` registered by one cycle. When `tx_off` was high, the gated lines `line_out[1:0]` are 0, while `line_out[2]` still carries `ser_bit`.
- R11: A next-boundary load happens only once. If both enables are high at the boundary after it, that boundary produces FILL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Byte to send |
| spec_sel | input | 1 | High: encode the byte as a control code; raw bit 8 in raw mode |
| viol_req | input | 1 | High: send a violation symbol; raw bit 9 in raw mode |
| en_now_n | input | 1 | Active-low load of the byte at this boundary |
| en_next_n | input | 1 | Active-low load of the byte at the next boundary |
| raw_mode | input | 1 | High: bypass the encoder with a 10-bit word |
| ser_bit | input | 1 | Serial bit from the serializer |
| tx_off | input | 1 | Forces the gated lines to zero |
| sym_kind | output | 3 | Symbol kind: 0 DATA, 1 SPECIAL, 2 VIOL, 3 FILL, 4 RAW |
| sym_word | output | 10 | Byte or raw word for the encoder |
| sym_valid | output | 1 | One-cycle pulse after each boundary |
| rd_n | output | 1 | Active-low FIFO read strobe |
| line_out | output | 3 | Registered serial lines; bits 1:0 gated by tx_off |

## Verification
The assertions assume that the control and data inputs are stable at the boundary edge on which they are sampled. They also assume that reset is high from time zero.

The bench keeps within these assumptions. It changes inputs only on falling edges, right after it sees the `sym_valid` pulse. It then holds them for the whole byte period, so every boundary samples one well-defined input set.

The assertions make no assumption about which combinations of enables, violation requests and mode are legal. For that reason, the stimulus table deliberately mixes violation with raw mode, and both enables low together.

// File: rtl/tx_front_pkg.sv
package tx_front_pkg;
   typedef enum logic [2:0] {
      SYM_DATA    = 3'd0,
      SYM_SPECIAL = 3'd1,
      SYM_VIOL    = 3'd2,
      SYM_FILL    = 3'd3,
      SYM_RAW     = 3'd4
   } sym_kind_e;

   localparam int KIND_W = 3;
endpackage

// File: rtl/tx_slot_timer.sv
// Counts bit slots within a byte period, flags the boundary, and shapes the
// read strobe window for the period that follows an immediate-enable boundary.
module tx_slot_timer #(
   parameter int SLOTS     = 10,
   parameter int LOW_SLOTS = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_in,
   output logic tick,
   output logic rd_n
);
   localparam int CW = (SLOTS > 2) ? $clog2(SLOTS) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);
   localparam logic [CW-1:0] LOWN = CW'(LOW_SLOTS);

   logic [CW-1:0] slot_q;
   logic          armed_q;

   assign tick = (slot_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (tick) begin
            slot_q  <= '0;
            armed_q <= arm_in;
         end else begin
            slot_q  <= slot_q + CW'(1);
         end
      end
   end

   assign rd_n = !(armed_q && (slot_q < LOWN));
endmodule

// File: rtl/tx_load_ctrl.sv
// Decides whether a boundary loads user data: either the immediate enable or
// a load requested one boundary earlier through the next-boundary enable.
module tx_load_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic en_now_n,
   input  logic en_next_n,
   output logic load,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= !en_next_n;
      end
   end

   assign load = !en_now_n || pend_q;
   assign pend = pend_q;
endmodule

// File: rtl/tx_sym_select.sv
// Picks the symbol request at each boundary and holds it for the byte period.
module tx_sym_select
   import tx_front_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] FILL_CODE = DATA_W'(8'hBC),
   localparam int               RAW_W     = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              load,
   input  logic              raw_mode,
   input  logic              viol_req,
   input  logic              spec_sel,
   input  logic [DATA_W-1:0] data_in,
   output logic [KIND_W-1:0] kind,
   output logic [RAW_W-1:0]  word,
   output logic              valid
);
   localparam logic [RAW_W-1:0] FILL_WORD = {1'b0, 1'b1, FILL_CODE};

   sym_kind_e        kind_d, kind_q;
   logic [RAW_W-1:0] word_d, word_q;
   logic             valid_q;

   always_comb begin
      kind_d = SYM_FILL;
      word_d = FILL_WORD;
      if (raw_mode) begin
         if (load) begin
            kind_d = SYM_RAW;
            word_d = {viol_req, spec_sel, data_in};
         end
      end else if (viol_req) begin
         kind_d = SYM_VIOL;
         word_d = '0;
      end else if (load) begin
         kind_d = spec_sel ? SYM_SPECIAL : SYM_DATA;
         word_d = {2'b00, data_in};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q  <= SYM_FILL;
         word_q  <= FILL_WORD;
         valid_q <= 1'b0;
      end else begin
         valid_q <= tick;
         if (tick) begin
            kind_q <= kind_d;
            word_q <= word_d;
         end
      end
   end

   assign kind  = kind_q;
   assign word  = word_q;
   assign valid = valid_q;
endmodule

// File: rtl/tx_line_gate.sv
// Registers the serial bit onto each output line; the low lines are gated.
module tx_line_gate #(
   parameter int NUM_LINES   = 3,
   parameter int GATED_LINES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ser_bit,
   input  logic                 tx_off,
   output logic [NUM_LINES-1:0] line_out
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic bit_q;
      if (i < GATED_LINES) begin : g_gated
         always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= ser_bit && !tx_off;
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= ser_bit;
         end
      end
      assign line_out[i] = bit_q;
   end
endmodule

// File: rtl/tx_symbol_front.sv
module tx_symbol_front
   import tx_front_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                SLOTS       = 10,
   parameter int                LOW_SLOTS   = 6,
   parameter int                NUM_LINES   = 3,
   parameter int                GATED_LINES = 2,
   parameter logic [DATA_W-1:0] FILL_CODE   = DATA_W'(8'hBC),
   localparam int               RAW_W       = DATA_W + 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [DATA_W-1:0]    data_in,
   input  logic                 spec_sel,
   input  logic                 viol_req,
   input  logic                 en_now_n,
   input  logic                 en_next_n,
   input  logic                 raw_mode,
   input  logic                 ser_bit,
   input  logic                 tx_off,
   output logic [KIND_W-1:0]    sym_kind,
   output logic [RAW_W-1:0]     sym_word,
   output logic                 sym_valid,
   output logic                 rd_n,
   output logic [NUM_LINES-1:0] line_out
);
   initial begin
      assert (SLOTS >= 2) else $error("SLOTS must be at least 2");
      assert (LOW_SLOTS >= 1 && LOW_SLOTS < SLOTS) else $error("LOW_SLOTS out of range");
      assert (GATED_LINES >= 1 && GATED_LINES < NUM_LINES) else $error("GATED_LINES out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic tick;
   logic load;
   logic next_pend;

   tx_slot_timer #(.SLOTS(SLOTS), .LOW_SLOTS(LOW_SLOTS)) u_timer (
      .clk(clk), .rst(rst), .arm_in(!en_now_n), .tick(tick), .rd_n(rd_n)
   );

   tx_load_ctrl u_load (
      .clk(clk), .rst(rst), .tick(tick), .en_now_n(en_now_n),
      .en_next_n(en_next_n), .load(load), .pend(next_pend)
   );

   tx_sym_select #(.DATA_W(DATA_W), .FILL_CODE(FILL_CODE)) u_sel (
      .clk(clk), .rst(rst), .tick(tick), .load(load), .raw_mode(raw_mode),
      .viol_req(viol_req), .spec_sel(spec_sel), .data_in(data_in),
      .kind(sym_kind), .word(sym_word), .valid(sym_valid)
   );

   tx_line_gate #(.NUM_LINES(NUM_LINES), .GATED_LINES(GATED_LINES)) u_lines (
      .clk(clk), .rst(rst), .ser_bit(ser_bit), .tx_off(tx_off), .line_out(line_out)
   );
endmodule

// File: rtl/tx_symbol_front_chk.sv
module tx_symbol_front_chk
   import tx_front_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_LINES   = 3,
   parameter int GATED_LINES = 2,
   localparam int RAW_W      = DATA_W + 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic [DATA_W-1:0]    data_in,
   input logic                 spec_sel,
   input logic                 viol_req,
   input logic                 en_now_n,
   input logic                 en_next_n,
   input logic                 raw_mode,
   input logic                 ser_bit,
   input logic                 tx_off,
   input logic [KIND_W-1:0]    sym_kind,
   input logic [RAW_W-1:0]     sym_word,
   input logic                 sym_valid,
   input logic                 rd_n,
   input logic [NUM_LINES-1:0] line_out,
   input logic                 next_pend
);
   p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
      sym_valid |=> !sym_valid);

   p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |-> ($stable(sym_kind) && $stable(sym_word)));

   p_strobe_start_r9: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> (rd_n == $past(en_now_n)));

   p_pend_capture_r3: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> (next_pend == $past(!en_next_n)));

   p_fill_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && $past(en_now_n && !next_pend && !(viol_req && !raw_mode)))
      |-> (sym_kind == KIND_W'(SYM_FILL)));

   p_data_load_r2: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && $past(!en_now_n && !raw_mode && !viol_req && !spec_sel))
      |-> (sym_kind == KIND_W'(SYM_DATA) && sym_word == {2'b00, $past(data_in)}));

   p_gate_off_r10: assert property (@(posedge clk) disable iff (rst)
      $past(tx_off) |-> (line_out[GATED_LINES-1:0] == '0));

   p_loop_line_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (line_out[NUM_LINES-1] == $past(ser_bit)));
endmodule

bind tx_symbol_front tx_symbol_front_chk #(
   .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .GATED_LINES(GATED_LINES)
) u_chk (.*);

// File: tb/sim_tx_symbol_front.sv
module sim_tx_symbol_front;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] data_in = 8'h00;
   logic       spec_sel = 1'b0, viol_req = 1'b0, en_now_n = 1'b1, en_next_n = 1'b1;
   logic       raw_mode = 1'b0, ser_bit = 1'b0, tx_off = 1'b0;
   logic [2:0] sym_kind;
   logic [9:0] sym_word;
   logic       sym_valid, rd_n;
   logic [2:0] line_out;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   tx_symbol_front u0 (
      .clk(clk), .rst(rst), .data_in(data_in), .spec_sel(spec_sel),
      .viol_req(viol_req), .en_now_n(en_now_n), .en_next_n(en_next_n),
      .raw_mode(raw_mode), .ser_bit(ser_bit), .tx_off(tx_off),
      .sym_kind(sym_kind), .sym_word(sym_word), .sym_valid(sym_valid),
      .rd_n(rd_n), .line_out(line_out)
   );

   // fields: raw viol spec en_now_n en_next_n data[8] kind[3] word[10] rd_n
   localparam int NV = 14;
   localparam logic [26:0] VEC [NV] = '{
      {1'b0,1'b0,1'b0,1'b0,1'b1,8'hA5,3'd0,10'h0A5,1'b0},  // R2
      {1'b0,1'b0,1'b1,1'b0,1'b1,8'h1C,3'd1,10'h01C,1'b0},  // R5
      {1'b0,1'b0,1'b0,1'b1,1'b1,8'h77,3'd3,10'h1BC,1'b1},  // R4
      {1'b0,1'b0,1'b0,1'b1,1'b0,8'h33,3'd3,10'h1BC,1'b1},  // R3 request
      {1'b0,1'b0,1'b0,1'b1,1'b1,8'h5A,3'd0,10'h05A,1'b1},  // R3 load
      {1'b0,1'b0,1'b0,1'b1,1'b1,8'h99,3'd3,10'h1BC,1'b1},  // R11
      {1'b0,1'b1,1'b1,1'b0,1'b1,8'hFF,3'd2,10'h000,1'b0},  // R6
      {1'b0,1'b1,1'b0,1'b1,1'b1,8'hC3,3'd2,10'h000,1'b1},  // R6 idle
      {1'b1,1'b1,1'b0,1'b0,1'b1,8'h3C,3'd4,10'h23C,1'b0},  // R7
      {1'b1,1'b1,1'b0,1'b1,1'b1,8'h11,3'd3,10'h1BC,1'b1},  // R7 idle
      {1'b1,1'b0,1'b1,1'b1,1'b0,8'h0F,3'd3,10'h1BC,1'b1},  // R7 request
      {1'b1,1'b0,1'b1,1'b1,1'b1,8'h80,3'd4,10'h180,1'b1},  // R7 load
      {1'b0,1'b0,1'b0,1'b0,1'b0,8'h42,3'd0,10'h042,1'b0},  // R2 both low
      {1'b0,1'b0,1'b0,1'b1,1'b1,8'h24,3'd0,10'h024,1'b1}   // R3 pending
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_sym();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!sym_valid && guard < 50);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      // R1: values during reset
      check(sym_kind == 3'd3, "R1 kind", sym_kind, 3);
      check(sym_word == 10'h1BC, "R1 word", sym_word, 'h1BC);
      check(sym_valid == 1'b0, "R1 valid", sym_valid, 0);
      check(rd_n == 1'b1, "R1 rd_n", rd_n, 1);

      // set a pending load, then reset: it must be dropped (R1)
      rst = 1'b0;
      en_next_n = 1'b0;
      wait_sym();
      en_next_n = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sym_valid && n < 50);
      check(n == 10, "R8 first pulse", n, 10);
      check(sym_kind == 3'd3, "R1 pend cleared", sym_kind, 3);
      @(negedge clk);
      check(sym_valid == 1'b0, "R8 one cycle", sym_valid, 0);
      n = 1;
      while (!sym_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      check(n == 10, "R8 period", n, 10);

      // table walk
      for (int i = 0; i < NV; i++) begin
         {raw_mode, viol_req, spec_sel, en_now_n, en_next_n, data_in} = VEC[i][26:14];
         wait_sym();
         check(sym_kind == VEC[i][13:11], $sformatf("vec%0d kind R2-R7", i), sym_kind, VEC[i][13:11]);
         check(sym_word == VEC[i][10:1], $sformatf("vec%0d word R2-R7", i), sym_word, VEC[i][10:1]);
         check(rd_n == VEC[i][0], $sformatf("vec%0d R9 rd_n", i), rd_n, VEC[i][0]);
      end

      // R9: strobe width within the period
      raw_mode = 1'b0; viol_req = 1'b0; spec_sel = 1'b0; en_next_n = 1'b1;
      en_now_n = 1'b0; data_in = 8'h6E;
      wait_sym();
      en_now_n = 1'b1;
      repeat (5) @(negedge clk);
      check(rd_n == 1'b0, "R9 slot5 low", rd_n, 0);
      @(negedge clk);
      check(rd_n == 1'b1, "R9 slot6 high", rd_n, 1);
      wait_sym();
      repeat (2) @(negedge clk);
      check(rd_n == 1'b1, "R9 idle high", rd_n, 1);

      // R10: line gating
      ser_bit = 1'b1; tx_off = 1'b1;
      @(negedge clk);
      check(line_out == 3'b100, "R10 off", line_out, 3'b100);
      tx_off = 1'b0;
      @(negedge clk);
      check(line_out == 3'b111, "R10 on", line_out, 3'b111);
      ser_bit = 1'b0;
      @(negedge clk);
      check(line_out == 3'b000, "R10 zero", line_out, 3'b000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule